// File: doc/BRIEF.md
# GPIO Pin Configuration and Multiplexer

This block serves one bank of 32 general-purpose pins. For each pin it decides who drives the pad: the bank's own GPIO logic, or one of four alternate peripheral functions selected by a two-bit code. It also holds the per-pin output-enable, output-data, pull-up, pull-down and open-drain settings. It drives the pad output, the pad output enable and the two pull controls. It also samples the pad level every clock, so that software can read it back.

Software reaches the block through a simple single-cycle register port. Every on/off control is built from three word addresses: a set strobe, a clear strobe and a readable status. Writing a mask to a set or clear strobe changes only the pins whose mask bit is 1, so a driver never needs a read-modify-write sequence. The two planes of the function select are plain read/write registers. Read data is combinational: it is valid in the same cycle as the address.

Top module: `gpio_pinmux_bank`

## Requirements
- R1: After reset, all pins are under GPIO control, the output enable is 0, the data latch is 0, the pull-up is 1 on every pin, the pull-down is 0, open-drain is off and both select planes are 0 (function A).
- R2: Control pairs use word address 3k for set, 3k+1 for clear and 3k+2 for status, with k = 0 owner (1 = GPIO), 1 output enable, 2 data latch, 3 pull-up, 4 pull-down and 5 open-drain. Writing 3*0 hands the pins in the mask to GPIO, and writing 1 hands them to their peripheral.
- R3: A write to address 3 sets output enable on the masked pins. A write to address 4 clears it. Address 5 reads it back.
- R4: A write to address 6 sets the data latch and a write to address 7 clears it. Mask bits that are 0 leave a pin unchanged, in every control pair.
- R5: Addresses 9 and 10 set and clear the pull-up, and addresses 12 and 13 set and clear the pull-down. A pull-down set also clears the pull-up of the same pins. The pad_pu and pad_pd outputs follow these status registers.
- R6: Address 18 holds the low select bit of each pin and address 19 the high bit. Both are read/write. A peripheral-owned pin takes its source lines from periph_dout and periph_doe at index code*32+pin, where code = {high, low}, and codes 0 to 3 are functions A to D.
- R7: A GPIO-owned pin without open-drain drives pad_out from its data latch and pad_oe from its output-enable bit.
- R8: With open-drain on, pad_out is 0 and pad_oe equals the source enable AND NOT the source data, for either owner.
- R9: Address 20 returns the pad_in level registered at the previous clock edge, whatever the owner of the pin.
- R10: Reads of set and clear strobe addresses, and of any address above 20, return 0. A write to the status, select-free or unused addresses changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Word address of the register port |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data or pin mask |
| reg_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output data |
| pad_oe | output | 32 | Pad output enable |
| pad_pu | output | 32 | Pull-up enable per pad |
| pad_pd | output | 32 | Pull-down enable per pad |
| periph_dout | input | 128 | Peripheral output lines, function-major (f*32+pin) |
| periph_doe | input | 128 | Peripheral output-enable lines, same ordering |

## Verification
The hardest situations to reach are those where several settings overlap on the same pin. One is a pin handed to a peripheral with a non-zero select code while open-drain is on. Another is a pull-down set that lands on pins whose pull-up is still on. The bench reaches both by running long stretches of random writes: random addresses, random masks, random peripheral lines and random pad levels. These are seeded with directed writes that turn on open-drain, place every select code on some pins and set the pull-down over a field of enabled pull-ups. A behavioural model compares every output on every cycle, so any overlap that the random stream creates is checked.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;
  localparam int NUM_PAIRS = 6;
  typedef enum int {PR_OWN = 0, PR_OE = 1, PR_DAT = 2, PR_PU = 3, PR_PD = 4, PR_OD = 5} pair_e;

  localparam int ADDR_SEL_LO = 3 * NUM_PAIRS;
  localparam int ADDR_SEL_HI = ADDR_SEL_LO + 1;
  localparam int ADDR_PAD    = ADDR_SEL_LO + 2;

  function automatic int pair_set_addr(int k);
    return 3 * k;
  endfunction

  function automatic int pair_clr_addr(int k);
    return 3 * k + 1;
  endfunction

  function automatic int pair_stat_addr(int k);
    return 3 * k + 2;
  endfunction

  // true when the address is a set or clear strobe
  function automatic bit is_strobe(int a);
    return (a < ADDR_SEL_LO) && ((a % 3) != 2);
  endfunction

  // reset level of a control pair: owner and pull-up start at ones
  function automatic bit pair_rst_ones(int k);
    return (k == PR_OWN) || (k == PR_PU);
  endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W        = 32,
  parameter bit RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] kill,
  output logic [W-1:0] q
);
  logic [W-1:0] set_bits, clr_bits;
  assign set_bits = set_stb ? mask : '0;
  assign clr_bits = (clr_stb ? mask : '0) | kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_ONES ? '1 : '0;
    else        q <= (q | set_bits) & ~clr_bits;
  end

  // R4: cleared mask bits are zero the cycle after a clear strobe
  p_clr_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((q & $past(mask)) == '0));

  // R4: bits outside the mask and kill keep their value
  p_unmasked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb) |=> ((q & ~$past(mask | kill)) == ($past(q) & ~$past(mask | kill))));
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pinmux_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [AW-1:0]                   addr,
  input  logic                            wr,
  input  logic [NPINS-1:0]                wdata,
  input  logic [NPINS-1:0]                pad_in,
  output logic [NPINS-1:0]                rdata,
  output logic [NUM_PAIRS-1:0][NPINS-1:0] pair_q,
  output logic [NPINS-1:0]                sel_lo,
  output logic [NPINS-1:0]                sel_hi
);
  logic [NPINS-1:0] pad_q;
  logic [NPINS-1:0] pu_kill;
  logic             pd_set_hit;

  assign pd_set_hit = wr && (addr == AW'(pair_set_addr(PR_PD)));
  assign pu_kill    = pd_set_hit ? wdata : '0;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic set_hit, clr_hit;
    assign set_hit = wr && (addr == AW'(pair_set_addr(k)));
    assign clr_hit = wr && (addr == AW'(pair_clr_addr(k)));
    gpio_setclr_reg #(.W(NPINS), .RST_ONES(pair_rst_ones(k))) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_stb(set_hit),
      .clr_stb(clr_hit),
      .mask   (wdata),
      .kill   ((k == PR_PU) ? pu_kill : '0),
      .q      (pair_q[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lo <= '0;
      sel_hi <= '0;
    end else if (wr) begin
      if (addr == AW'(ADDR_SEL_LO)) sel_lo <= wdata;
      if (addr == AW'(ADDR_SEL_HI)) sel_hi <= wdata;
    end
  end

  // pad level sampled every clock, independent of owner
  always_ff @(posedge clk) pad_q <= pad_in;

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_PAIRS; k++)
      if (addr == AW'(pair_stat_addr(k))) rdata = pair_q[k];
    if (addr == AW'(ADDR_SEL_LO)) rdata = sel_lo;
    if (addr == AW'(ADDR_SEL_HI)) rdata = sel_hi;
    if (addr == AW'(ADDR_PAD))    rdata = pad_q;
  end

  // R5: pull-down set removes the pull-up of the same pins
  p_pd_kills_pu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pd_set_hit |=> ((pair_q[PR_PU] & $past(wdata)) == '0));

  // R3: output-enable set strobe lands on every masked pin
  p_oe_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == AW'(pair_set_addr(PR_OE))) |=>
      ((pair_q[PR_OE] & $past(wdata)) == $past(wdata)));

  // R2: handing pins to GPIO takes effect the next cycle
  p_own_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == AW'(pair_set_addr(PR_OWN))) |=>
      ((pair_q[PR_OWN] & $past(wdata)) == $past(wdata)));

  // R9: pad status equals the pad one clock earlier
  p_pad_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(ADDR_PAD)) |-> (rdata == $past(pad_in)));

  // R10: strobe addresses read as zero
  p_strobe_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_strobe(int'(addr)) |-> (rdata == '0));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NPINS = 32,
  parameter int SELW  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPINS-1:0]            own_gpio,
  input  logic [NPINS-1:0]            gpio_oe,
  input  logic [NPINS-1:0]            gpio_dat,
  input  logic [NPINS-1:0]            od_en,
  input  logic [NPINS-1:0]            sel_lo,
  input  logic [NPINS-1:0]            sel_hi,
  input  logic [(NPINS<<SELW)-1:0]    fn_dout,
  input  logic [(NPINS<<SELW)-1:0]    fn_doe,
  output logic [NPINS-1:0]            pad_out,
  output logic [NPINS-1:0]            pad_oe
);
  logic [NPINS-1:0] src_out, src_oe;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [SELW-1:0] code;
    assign code       = {sel_hi[p], sel_lo[p]};
    assign src_out[p] = own_gpio[p] ? gpio_dat[p] : fn_dout[int'(code) * NPINS + p];
    assign src_oe[p]  = own_gpio[p] ? gpio_oe[p]  : fn_doe[int'(code) * NPINS + p];
    assign pad_out[p] = od_en[p] ? 1'b0 : src_out[p];
    assign pad_oe[p]  = od_en[p] ? (src_oe[p] & ~src_out[p]) : src_oe[p];
  end

  // R8: an open-drain pin never drives a high level
  p_od_never_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((od_en & pad_oe & pad_out) == '0));

  // R7: plain GPIO pins follow their latch and enable
  p_gpio_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ gpio_dat) | (pad_oe ^ gpio_oe)) & own_gpio & ~od_en) == '0);
endmodule

// File: rtl/gpio_pinmux_bank.sv
module gpio_pinmux_bank
  import gpio_pinmux_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 5,
  parameter int SELW  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             reg_addr,
  input  logic                      reg_wr,
  input  logic [NPINS-1:0]          reg_wdata,
  output logic [NPINS-1:0]          reg_rdata,
  input  logic [NPINS-1:0]          pad_in,
  output logic [NPINS-1:0]          pad_out,
  output logic [NPINS-1:0]          pad_oe,
  output logic [NPINS-1:0]          pad_pu,
  output logic [NPINS-1:0]          pad_pd,
  input  logic [(NPINS<<SELW)-1:0]  periph_dout,
  input  logic [(NPINS<<SELW)-1:0]  periph_doe
);
  logic [NUM_PAIRS-1:0][NPINS-1:0] pair_q;
  logic [NPINS-1:0]                sel_lo, sel_hi;

  gpio_cfg_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (reg_addr),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .pad_in(pad_in),
    .rdata (reg_rdata),
    .pair_q(pair_q),
    .sel_lo(sel_lo),
    .sel_hi(sel_hi)
  );

  gpio_pad_mux #(.NPINS(NPINS), .SELW(SELW)) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .own_gpio(pair_q[PR_OWN]),
    .gpio_oe (pair_q[PR_OE]),
    .gpio_dat(pair_q[PR_DAT]),
    .od_en   (pair_q[PR_OD]),
    .sel_lo  (sel_lo),
    .sel_hi  (sel_hi),
    .fn_dout (periph_dout),
    .fn_doe  (periph_doe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  assign pad_pu = pair_q[PR_PU];
  assign pad_pd = pair_q[PR_PD];

  // R5: pull-up and pull-down leave a pin enabled together only through a later pull-up set
  p_pull_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(pair_set_addr(PR_PD))) |=> ((pad_pu & pad_pd & $past(reg_wdata)) == '0));
endmodule

// File: tb/gpio_pinmux_bank_tb.sv
`timescale 1ns/1ps
module gpio_pinmux_bank_tb;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe, pad_pu, pad_pd;
  logic [4*N-1:0] periph_dout = '0, periph_doe = '0;

  always #2.5 clk = ~clk;

  gpio_pinmux_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .periph_dout(periph_dout), .periph_doe(periph_doe)
  );

  // behavioural reference state
  logic [N-1:0] m_own, m_oe, m_dat, m_pu, m_pd, m_od, m_lo, m_hi, m_pad;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] m_read(input int a);
    case (a)
      2:  return m_own;
      5:  return m_oe;
      8:  return m_dat;
      11: return m_pu;
      14: return m_pd;
      17: return m_od;
      18: return m_lo;
      19: return m_hi;
      20: return m_pad;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    if (a < 3)  return "R2 owner read";
    if (a < 6)  return "R3 oe read";
    if (a < 9)  return "R4 data read";
    if (a < 15) return "R5 pull read";
    if (a < 18) return "R8 od read";
    if (a < 20) return "R6 select read";
    if (a == 20) return "R9 pad read";
    return "R10 unused read";
  endfunction

  task automatic compare_all();
    logic [N-1:0] eo, ee;
    for (int p = 0; p < N; p++) begin
      int f;
      logic so, se;
      f  = (m_hi[p] ? 2 : 0) + (m_lo[p] ? 1 : 0);
      so = m_own[p] ? m_dat[p] : periph_dout[f*N+p];
      se = m_own[p] ? m_oe[p]  : periph_doe[f*N+p];
      eo[p] = m_od[p] ? 1'b0 : so;
      ee[p] = m_od[p] ? (se && !so) : se;
    end
    if (reg_addr > 17 || (reg_addr % 3) == 2) check(tag_of(int'(reg_addr)), reg_rdata, m_read(int'(reg_addr)));
    else check("R10 strobe read", reg_rdata, '0);
    check("R6/R7/R8 pad_out", pad_out, eo);
    check("R6/R7/R8 pad_oe", pad_oe, ee);
    check("R5 pad_pu", pad_pu, m_pu);
    check("R5 pad_pd", pad_pd, m_pd);
  endtask

  task automatic model_update(input logic w, input int a, input logic [N-1:0] d, input logic [N-1:0] pin);
    m_pad = pin;
    if (!w) return;
    case (a)
      0:  m_own |= d;   1:  m_own &= ~d;
      3:  m_oe  |= d;   4:  m_oe  &= ~d;
      6:  m_dat |= d;   7:  m_dat &= ~d;
      9:  m_pu  |= d;   10: m_pu  &= ~d;
      12: begin m_pd |= d; m_pu &= ~d; end
      13: m_pd  &= ~d;
      15: m_od  |= d;   16: m_od  &= ~d;
      18: m_lo = d;     19: m_hi = d;
      default: ;
    endcase
  endtask

  task automatic cycle(input logic w, input int a, input logic [N-1:0] d, input logic [N-1:0] pin);
    @(negedge clk);
    reg_wr = w; reg_addr = 5'(a); reg_wdata = d; pad_in = pin;
    #1 compare_all();
    @(posedge clk);
    model_update(w, a, d, pin);
  endtask

  task automatic rd(input int a);
    cycle(1'b0, a, '0, pad_in);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_own = '1; m_oe = '0; m_dat = '0; m_pu = '1; m_pd = '0; m_od = '0;
    m_lo = '0; m_hi = '0; m_pad = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values across every address
    for (int a = 0; a < 24; a++) rd(a);
    check("R1 reset pu", pad_pu, '1);
    check("R1 reset pd", pad_pd, '0);
    // R7: gpio output with data pattern
    cycle(1, 6, 32'hA5A5_00FF, 32'h1234_5678);
    cycle(1, 3, 32'h0F0F_F0F0, 32'h1234_5678);
    rd(5); rd(8); rd(20);
    cycle(1, 7, 32'h0000_000F, 32'hFFFF_0000);
    rd(8);
    // R6: hand upper half to peripherals, all four codes present
    periph_dout = {32'hDEAD_BEEF, 32'h1357_9BDF, 32'h0F1E_2D3C, 32'hF00D_CAFE};
    periph_doe  = {32'hFFFF_0000, 32'h00FF_FF00, 32'hAAAA_5555, 32'h3333_CCCC};
    cycle(1, 18, 32'hCCCC_CCCC, 32'h0);
    cycle(1, 19, 32'hF0F0_F0F0, 32'h0);
    cycle(1, 1,  32'hFFFF_0000, 32'h0);
    rd(2); rd(18); rd(19);
    // R8: open-drain on peripheral and gpio pins
    cycle(1, 15, 32'h00FF_FF00, 32'h0);
    rd(17);
    cycle(1, 16, 32'h0000_FF00, 32'h0);
    // R5: pull-down over enabled pull-ups, then re-enable one pull-up
    cycle(1, 12, 32'h8000_0001, 32'h0);
    rd(11); rd(14);
    cycle(1, 9, 32'h0000_0001, 32'h0);
    cycle(1, 13, 32'h8000_0000, 32'h0);
    rd(11); rd(14);
    // R10: writes to status and unused addresses have no effect
    cycle(1, 2, 32'hFFFF_FFFF, 32'h0);
    cycle(1, 21, 32'hFFFF_FFFF, 32'h0);
    cycle(1, 31, 32'hFFFF_FFFF, 32'h0);
    rd(2); rd(5); rd(21);
    // random stretch, every output compared each cycle
    for (int i = 0; i < 3000; i++) begin
      periph_dout = {$urandom, $urandom, $urandom, $urandom};
      periph_doe  = {$urandom, $urandom, $urandom, $urandom};
      cycle(1'($urandom_range(0, 1)), int'($urandom_range(0, 23)), N'($urandom), N'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule